// File: doc/BRIEF.md
# E1 Timeslot Data-Link Bit Inserter

This block sits in the transmit path of a 2.048 Mbit/s E1 line, after the framer. It replaces selected payload bits with bits taken from a serial data-link source, such as an HDLC transmitter. It counts the 256 bit periods of each frame from a frame-sync pulse, or runs freely once it has locked. It also tracks which frames carry the frame alignment signal (even, FAS) and which do not (odd, NFAS).

Software selects four things:
- whether FAS frames carry the link;
- whether NFAS frames carry the link;
- a 5-bit timeslot number;
- an 8-bit mask of the bit positions in that timeslot that are replaced.

In every enabled bit period the block raises a one-cycle request to the source. It samples the source's bit in the same cycle and drives that bit onto the output. All other bits pass through unchanged.

The output is registered. It shows the result of a bit period one clock after that period's bit-enable cycle. A configuration write is held in a pending copy and becomes active only at the next frame boundary.

Top module: `tsl_inserter`

## Requirements
- R1: After reset, dataOut is 0, linkReq is 0, and every configuration field (both frame enables, slot, mask) is 0, so nothing is inserted.
- R2: On every bit period (bitEn high) that is not selected for insertion, dataOut takes the value of dataIn on the next clock edge. Cycles with bitEn low leave dataOut unchanged.
- R3: With only the FAS enable set, insertion happens only in even (FAS) frames.
- R4: With only the NFAS enable set, insertion happens only in odd (NFAS) frames.
- R5: Only bits of the timeslot whose number equals cfgSlot are replaced. Timeslot n covers frame bit positions 8n to 8n+7.
- R6: Mask bit 7 selects the first transmitted bit of the timeslot (position 8n) and mask bit 0 selects the last (8n+7). A selected bit is replaced on dataOut, at the next edge, by the linkBit value present in its request cycle. Source bits appear in the order they were requested.
- R7: When both frame enables are 0, no insertion takes place, whatever the slot and mask.
- R8: linkReq is high for exactly one cycle per inserted bit, and only in a cycle with bitEn high. The number of requests in a frame equals the mask popcount if that frame's type is enabled, and 0 otherwise.
- R9: A configuration write takes effect from bit 0 of the next frame. The frame in progress keeps the old settings throughout.
- R10: Frame parity starts odd at reset and toggles at every frame boundary. A frameSync with fasAlign high forces the new frame to even (FAS).
- R11: No bit is inserted before the first frameSync, whatever the configuration.
- R12: Once locked, the block starts a new frame after 256 bit periods even without a frameSync. A frameSync always restarts the frame at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One line bit period per cycle with bitEn high |
| frameSync | input | 1 | With bitEn: current bit is bit 0 of timeslot 0 |
| fasAlign | input | 1 | With frameSync: the new frame is a FAS (even) frame |
| dataIn | input | 1 | Payload bit of the current bit period |
| dataOut | output | 1 | Registered payload bit after insertion |
| cfgWe | input | 1 | Writes the pending configuration |
| cfgEvenEn | input | 1 | Insert in FAS (even) frames |
| cfgOddEn | input | 1 | Insert in NFAS (odd) frames |
| cfgSlot | input | 5 | Timeslot number carrying the link |
| cfgMask | input | 8 | Per-bit mask, bit 7 = first bit of slot |
| linkReq | output | 1 | Request one bit from the data-link source now |
| linkBit | input | 1 | Data-link bit, valid in the cycle of linkReq |

## Verification
The assertions assume three things about the inputs:
- frameSync and fasAlign are looked at only in cycles with bitEn high;
- the source presents linkBit in the same cycle as linkReq;
- configuration writes never rely on a particular bit period.

The stimulus holds frameSync and fasAlign low in cycles with bitEn low, and performs configuration writes only in idle cycles. It drives linkBit from a source model that advances one bit after each granted request. It keeps exactly 256 bit periods between boundaries, except in the pre-lock phase where no boundary exists yet.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int SLOTS     = 32;
  localparam int SLOT_BITS = 8;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int IDX_W     = $clog2(SLOT_BITS);
  localparam int POS_W     = SLOT_W + IDX_W;

  typedef struct packed {
    logic                 evenEn;
    logic                 oddEn;
    logic [SLOT_W-1:0]    slot;
    logic [SLOT_BITS-1:0] mask;
  } cfg_t;

  typedef struct packed {
    logic advance;
    logic insert;
  } strobe_t;
endpackage

// File: rtl/tsl_ctrl.sv
module tsl_ctrl
  import tsl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  input  logic    frameSync,
  input  logic    fasAlign,
  input  logic    cfgWe,
  input  cfg_t    cfgIn,
  output strobe_t stb
);
  localparam logic [POS_W-1:0] POS_LAST = '1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOT_BITS - 1);

  logic [POS_W-1:0] posQ, posCur;
  logic             oddQ, oddCur, framedQ, boundary, locked;
  logic             slotHit, maskHit, frameOk;
  logic [IDX_W-1:0] maskIdx;
  cfg_t             pendQ, actQ, effCfg;

  assign boundary = bitEn & (frameSync | (framedQ & (posQ == POS_LAST)));
  assign locked   = boundary | framedQ;

  always_comb begin
    posCur  = boundary ? '0 : posQ + 1'b1;
    oddCur  = boundary ? ((frameSync & fasAlign) ? 1'b0 : ~oddQ) : oddQ;
    effCfg  = boundary ? pendQ : actQ;
    maskIdx = IDX_LAST - posCur[IDX_W-1:0];
    slotHit = posCur[POS_W-1:IDX_W] == effCfg.slot;
    maskHit = effCfg.mask[maskIdx];
    frameOk = oddCur ? effCfg.oddEn : effCfg.evenEn;
    stb.advance = bitEn;
    stb.insert  = bitEn & locked & frameOk & slotHit & maskHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ    <= '0;
      oddQ    <= 1'b1;
      framedQ <= 1'b0;
      pendQ   <= '0;
      actQ    <= '0;
    end else begin
      if (cfgWe) pendQ <= cfgIn;
      if (bitEn) begin
        posQ    <= posCur;
        oddQ    <= oddCur;
        framedQ <= locked;
        if (boundary) actQ <= pendQ;
      end
    end
  end

  a_r8_req_needs_bit: assert property (@(posedge clk) disable iff (!rstN)
    stb.insert |-> bitEn);
  a_r10_parity_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !(frameSync && fasAlign)) |=> (oddQ != $past(oddQ)));
  a_r10_fas_align: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && frameSync && fasAlign) |=> !oddQ);
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(actQ));
  a_r11_no_early_insert: assert property (@(posedge clk) disable iff (!rstN)
    (!framedQ && !(bitEn && frameSync)) |-> !stb.insert);
endmodule

// File: rtl/tsl_dpath.sv
module tsl_dpath
  import tsl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    dataIn,
  input  logic    linkBit,
  output logic    dataOut
);
  always_ff @(posedge clk) begin
    if (!rstN)            dataOut <= 1'b0;
    else if (stb.advance) dataOut <= stb.insert ? linkBit : dataIn;
  end

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.insert) |=> dataOut == $past(dataIn));
  a_r6_link_taken: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && stb.insert) |=> dataOut == $past(linkBit));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(dataOut));
endmodule

// File: rtl/tsl_inserter.sv
module tsl_inserter
  import tsl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitEn,
  input  logic                 frameSync,
  input  logic                 fasAlign,
  input  logic                 dataIn,
  output logic                 dataOut,
  input  logic                 cfgWe,
  input  logic                 cfgEvenEn,
  input  logic                 cfgOddEn,
  input  logic [SLOT_W-1:0]    cfgSlot,
  input  logic [SLOT_BITS-1:0] cfgMask,
  output logic                 linkReq,
  input  logic                 linkBit
);
  cfg_t    cfgIn;
  strobe_t stb;

  assign cfgIn   = '{evenEn: cfgEvenEn, oddEn: cfgOddEn, slot: cfgSlot, mask: cfgMask};
  assign linkReq = stb.insert;

  tsl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
    .fasAlign(fasAlign), .cfgWe(cfgWe), .cfgIn(cfgIn), .stb(stb)
  );

  tsl_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn),
    .linkBit(linkBit), .dataOut(dataOut)
  );
endmodule

// File: tb/sim_tsl_inserter.sv
module sim_tsl_inserter;
  logic clk = 1'b0;
  logic rstN, bitEn, frameSync, fasAlign, dataIn, dataOut;
  logic cfgWe, cfgEvenEn, cfgOddEn, linkReq, linkBit;
  logic [4:0] cfgSlot;
  logic [7:0] cfgMask;

  int checks = 0, errors = 0;
  int srcIdx = 0, mSrc = 0, frameIns = 0;
  logic [7:0] mPos = 0;
  logic mOdd = 1'b1, mFramed = 1'b0;
  logic mE = 0, mO = 0, pE = 0, pO = 0;
  logic [4:0] mTs = 0, pTs = 0;
  logic [7:0] mMask = 0, pMask = 0;
  logic   expQ[$];
  string  tagQ[$];

  always #5 clk = ~clk;

  tsl_inserter u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync), .fasAlign(fasAlign),
    .dataIn(dataIn), .dataOut(dataOut), .cfgWe(cfgWe), .cfgEvenEn(cfgEvenEn),
    .cfgOddEn(cfgOddEn), .cfgSlot(cfgSlot), .cfgMask(cfgMask),
    .linkReq(linkReq), .linkBit(linkBit)
  );

  function automatic logic srcBit(input int k);
    return k[0] ^ k[2] ^ k[3];
  endfunction

  assign linkBit = srcBit(srcIdx);

  task automatic check(input logic ok, input string what, input logic got, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %b exp %b", what, got, exp);
    end
  endtask

  task automatic checkInt(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", what, got, exp);
    end
  endtask

  // monitor: pops expected bits once the registered output has settled
  always @(posedge clk) begin
    logic took, req;
    took = bitEn;
    req  = linkReq;
    #2;
    if (req) srcIdx++;
    if (took && expQ.size() > 0) begin
      logic e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(dataOut === e, {t, " dataOut"}, dataOut, e);
    end
  end

  task automatic idle();
    @(negedge clk);
    bitEn = 0; frameSync = 0; fasAlign = 0; cfgWe = 0; dataIn = 1'($urandom);
    #1;
    check(linkReq === 1'b0, "R8 linkReq in idle cycle", linkReq, 1'b0);
  endtask

  task automatic cfgWrite(input logic e, input logic o, input logic [4:0] ts, input logic [7:0] m);
    @(negedge clk);
    bitEn = 0; frameSync = 0; fasAlign = 0;
    cfgWe = 1; cfgEvenEn = e; cfgOddEn = o; cfgSlot = ts; cfgMask = m;
    pE = e; pO = o; pTs = ts; pMask = m;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic bitCycle(input logic sync, input logic align, input string tag);
    logic bnd, sel;
    @(negedge clk);
    bitEn = 1; frameSync = sync; fasAlign = align; cfgWe = 0; dataIn = 1'($urandom);
    bnd = sync || (mFramed && mPos == 8'd255);
    if (bnd) begin
      mPos = 0; mOdd = (sync && align) ? 1'b0 : ~mOdd;
      mE = pE; mO = pO; mTs = pTs; mMask = pMask; mFramed = 1;
    end else mPos = mPos + 1;
    sel = mFramed && (mOdd ? mO : mE) && (mPos[7:3] == mTs) && mMask[3'd7 - mPos[2:0]];
    #1;
    check(linkReq === sel, {tag, " R8 linkReq"}, linkReq, sel);
    if (sel) begin
      expQ.push_back(srcBit(mSrc));
      tagQ.push_back({tag, " R6 inserted"});
      mSrc++;
    end else begin
      expQ.push_back(dataIn);
      tagQ.push_back({tag, " R2 pass"});
    end
    if (linkReq) frameIns++;
  endtask

  task automatic runFrame(input logic sync, input logic align, input string tag,
                          input logic doMid, input logic e, input logic o,
                          input logic [4:0] ts, input logic [7:0] m);
    int expCnt;
    frameIns = 0;
    for (int b = 0; b < 256; b++) begin
      bitCycle(sync && b == 0, align && b == 0, tag);
      if (b % 5 == 4) idle();
      if (doMid && b == 100) cfgWrite(e, o, ts, m);
    end
    expCnt = (mFramed && (mOdd ? mO : mE)) ? $countones(mMask) : 0;
    checkInt({tag, " R8 inserts per frame"}, frameIns, expCnt);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; bitEn = 0; frameSync = 0; fasAlign = 0; dataIn = 0;
    cfgWe = 0; cfgEvenEn = 0; cfgOddEn = 0; cfgSlot = 0; cfgMask = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check(dataOut === 1'b0, "R1 reset dataOut", dataOut, 1'b0);
    check(linkReq === 1'b0, "R1 reset linkReq", linkReq, 1'b0);
    // R1: configuration is zero, so a locked frame inserts nothing
    runFrame(1, 1, "R1", 0, 0, 0, 0, 0);

    // R11: configuration enabled but bit stream not yet synced after a new reset
    @(negedge clk); rstN = 0; mOdd = 1; mFramed = 0; mPos = 0;
    mE = 0; mO = 0; mTs = 0; mMask = 0; pE = 0; pO = 0; pTs = 0; pMask = 0;
    @(negedge clk); rstN = 1;
    cfgWrite(1, 0, 0, 8'hFF);
    frameIns = 0;
    for (int b = 0; b < 40; b++) bitCycle(0, 0, "R11");
    checkInt("R11 no insert before sync", frameIns, 0);

    runFrame(1, 1, "R3", 0, 0, 0, 0, 0);       // even: 8 inserts
    runFrame(0, 0, "R3", 0, 0, 0, 0, 0);       // odd: none
    cfgWrite(0, 1, 5'd31, 8'h3C);
    runFrame(1, 0, "R4", 0, 0, 0, 0, 0);       // sync toggles to even: none
    runFrame(0, 0, "R4", 0, 0, 0, 0, 0);       // odd: 4 inserts in slot 31
    cfgWrite(1, 1, 5'd5, 8'h81);
    runFrame(0, 0, "R5", 0, 0, 0, 0, 0);
    runFrame(0, 0, "R6", 0, 0, 0, 0, 0);
    cfgWrite(0, 0, 5'd2, 8'hFF);
    runFrame(0, 0, "R7", 0, 0, 0, 0, 0);
    runFrame(0, 0, "R9", 1, 1, 1, 5'd17, 8'hA5);  // old (none) kept this frame
    runFrame(0, 0, "R9", 0, 0, 0, 0, 0);          // new settings now active
    runFrame(1, 1, "R10", 0, 0, 0, 0, 0);         // forced even
    runFrame(0, 0, "R12", 0, 0, 0, 0, 0);         // free-running wrap
    cfgWrite(1, 0, 5'd0, 8'h80);
    runFrame(1, 1, "R12", 0, 0, 0, 0, 0);
    repeat (4) idle();
    checkInt("R6 source order consumed", srcIdx, mSrc);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule